// File: doc/BRIEF.md
# Cache invalidation sequencer

This block runs a full invalidation pass over a small tag CAM on software request. A single write of 1 to the start bit clears the done flag and both progress counters, then the engine sends one invalidate command per CAM entry, in index order. After each command it waits for the entry's completion, and it counts the commands issued and the completions received as it goes. When the last entry has completed, it raises done.

Each entry is allowed a bounded wait, set by an 8-bit wait-cycles input. If a completion does not arrive in that window, the pass stops in an abort state, raises a sticky abort flag and sends a one-cycle fatal interrupt pulse. Status visible to software covers the 3-bit state code, the issued and cleaned counters, the abort flag and a reset-ready flag that is high whenever no pass is running. The CAM itself and its lookup path live outside this block.

Top module: `cache_inval_seq`

## Requirements
- R1: After reset: state_code is 0, done, abort_flag, fatal_irq, start_busy and cmd_valid are 0, both counters are 0, and rst_rdy is 1.
- R2: A start_wr pulse accepted in state IDLE, DONE or ABORT does four things on the next cycle: it clears done and abort_flag, zeroes both counters, and sets start_busy. start_busy stays 1 for exactly that one cycle, so it is always 0 before done can be seen as 1.
- R3: A pass sends exactly NUM_ENTRIES commands with cmd_idx equal to 0, 1, 2 and so on in order. cmd_valid is high for one cycle per command and is never high on two consecutive cycles.
- R4: issued_cnt increases by one in the cycle after each command, so it equals the number of commands sent in the current pass.
- R5: cleaned_cnt increases by one for each inv_cmp seen while the block waits for a completion. An inv_cmp seen in any other state (idle, done, abort) is ignored. cleaned_cnt never exceeds issued_cnt.
- R6: With wait_cycles = W, a completion for an entry is accepted if it arrives within the first W+1 cycles after the command cycle. If it has not arrived by then, the block enters ABORT.
- R7: On entering ABORT, abort_flag becomes 1 and fatal_irq is 1 for exactly one cycle. abort_flag and the counters then hold until the next accepted start, and done stays 0.
- R8: Done becomes 1 two cycles after the cycle in which the last completion is seen, with issued_cnt and cleaned_cnt both equal to NUM_ENTRIES. It holds until the next accepted start.
- R9: state_code encodes IDLE=0, ISSUE=1, WAIT=2, CHECK=3, DONE=4, ABORT=5. cmd_valid is high exactly in ISSUE.
- R10: A start_wr while a pass is running (ISSUE, WAIT or CHECK) has no effect: start_busy stays 0, and the counters and the command order continue.
- R11: rst_rdy is 0 from the cycle after an accepted start until the pass ends in DONE or ABORT, and is 1 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_wr | input | 1 | Software write of 1 to the start bit |
| wait_cycles | input | 8 | Per-entry completion window minus one |
| inv_cmp | input | 1 | Completion of the outstanding invalidate |
| cmd_valid | output | 1 | Invalidate command strobe |
| cmd_idx | output | CNT_W | Entry index of the command |
| start_busy | output | 1 | Start bit read-back (self-clearing) |
| done | output | 1 | Pass completed |
| abort_flag | output | 1 | Pass aborted on missing completion |
| fatal_irq | output | 1 | One-cycle fatal interrupt pulse on abort |
| rst_rdy | output | 1 | No pass in progress |
| state_code | output | 3 | Encoded FSM state |
| issued_cnt | output | CNT_W | Commands issued in this pass |
| cleaned_cnt | output | CNT_W | Completions received in this pass |

## Verification
The start_busy flag and the ISSUE state appear one cycle after the edge that samples start_wr. issued_cnt moves one cycle after each cmd_valid, and cleaned_cnt moves on the edge that sees inv_cmp. Done or abort appears two edges after the last completion, or one edge after the window's final wait cycle. Stimulus changes on the falling edge and every output is read on a falling edge, counted from the command cycle, so the completion delay of each vector lands on a known wait cycle, including the last accepted one and the first rejected one.

// File: rtl/cis_pkg.sv
package cis_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_ISSUE = 3'd1,
        ST_WAIT  = 3'd2,
        ST_CHECK = 3'd3,
        ST_DONE  = 3'd4,
        ST_ABORT = 3'd5
    } cis_state_e;

    typedef struct packed {
        cis_state_e state;
        logic       start_bit;
        logic       done;
        logic       abort;
        logic       fatal;
        logic       idle_rdy;
    } cis_ctl_t;

endpackage

// File: rtl/cis_wait_timer.sv
module cis_wait_timer #(
    parameter int TIMER_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic [TIMER_W-1:0] load_val,
    input  logic               dec,
    output logic               expired
);
    logic [TIMER_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (dec && (cnt_q != '0)) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/cis_step_counter.sv
module cis_step_counter #(
    parameter int W = 9
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] value
);
    logic [W-1:0] value_d, value_q;

    always_comb begin
        value_d = value_q;
        if (clr)      value_d = '0;
        else if (inc) value_d = value_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) value_q <= '0;
        else        value_q <= value_d;
    end

    assign value = value_q;
endmodule

// File: rtl/cache_inval_seq.sv
module cache_inval_seq
    import cis_pkg::*;
#(
    parameter int NUM_ENTRIES = 8,
    parameter int CNT_W       = 9,
    parameter int TIMER_W     = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_wr,
    input  logic [TIMER_W-1:0] wait_cycles,
    input  logic               inv_cmp,
    output logic               cmd_valid,
    output logic [CNT_W-1:0]   cmd_idx,
    output logic               start_busy,
    output logic               done,
    output logic               abort_flag,
    output logic               fatal_irq,
    output logic               rst_rdy,
    output logic [2:0]         state_code,
    output logic [CNT_W-1:0]   issued_cnt,
    output logic [CNT_W-1:0]   cleaned_cnt
);
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(NUM_ENTRIES);
    localparam cis_ctl_t CTL_RST = '{state: ST_IDLE, start_bit: 1'b0, done: 1'b0,
                                     abort: 1'b0, fatal: 1'b0, idle_rdy: 1'b1};

    cis_ctl_t         ctl_d, ctl_q;
    logic [CNT_W-1:0] idx_d, idx_q;
    logic             accept;
    logic             tmr_load, tmr_dec, tmr_expired;
    logic             iss_inc, cln_inc, cnt_clr;

    cis_wait_timer #(.TIMER_W(TIMER_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(wait_cycles),
        .dec(tmr_dec), .expired(tmr_expired)
    );

    cis_step_counter #(.W(CNT_W)) u_issued (
        .clk(clk), .rst_n(rst_n), .clr(cnt_clr), .inc(iss_inc), .value(issued_cnt)
    );

    cis_step_counter #(.W(CNT_W)) u_cleaned (
        .clk(clk), .rst_n(rst_n), .clr(cnt_clr), .inc(cln_inc), .value(cleaned_cnt)
    );

    // Start is only taken when no pass is running.
    assign accept = start_wr && ((ctl_q.state == ST_IDLE) ||
                                 (ctl_q.state == ST_DONE) ||
                                 (ctl_q.state == ST_ABORT));

    always_comb begin
        ctl_d           = ctl_q;
        idx_d           = idx_q;
        ctl_d.start_bit = 1'b0;
        ctl_d.fatal     = 1'b0;
        tmr_load        = 1'b0;
        tmr_dec         = 1'b0;
        iss_inc         = 1'b0;
        cln_inc         = 1'b0;
        cnt_clr         = 1'b0;
        case (ctl_q.state)
            ST_IDLE, ST_DONE, ST_ABORT: begin
                if (accept) begin
                    ctl_d.state     = ST_ISSUE;
                    ctl_d.start_bit = 1'b1;
                    ctl_d.done      = 1'b0;
                    ctl_d.abort     = 1'b0;
                    ctl_d.idle_rdy  = 1'b0;
                    idx_d           = '0;
                    cnt_clr         = 1'b1;
                end
            end
            ST_ISSUE: begin
                iss_inc     = 1'b1;
                tmr_load    = 1'b1;
                ctl_d.state = ST_WAIT;
            end
            ST_WAIT: begin
                if (inv_cmp) begin
                    cln_inc     = 1'b1;
                    ctl_d.state = ST_CHECK;
                end else if (tmr_expired) begin
                    ctl_d.state    = ST_ABORT;
                    ctl_d.abort    = 1'b1;
                    ctl_d.fatal    = 1'b1;
                    ctl_d.idle_rdy = 1'b1;
                end else begin
                    tmr_dec = 1'b1;
                end
            end
            ST_CHECK: begin
                if (issued_cnt == LAST_CNT) begin
                    ctl_d.state    = ST_DONE;
                    ctl_d.done     = 1'b1;
                    ctl_d.idle_rdy = 1'b1;
                end else begin
                    ctl_d.state = ST_ISSUE;
                    idx_d       = idx_q + 1'b1;
                end
            end
            default: ctl_d = CTL_RST;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= CTL_RST;
            idx_q <= '0;
        end else begin
            ctl_q <= ctl_d;
            idx_q <= idx_d;
        end
    end

    assign cmd_valid  = (ctl_q.state == ST_ISSUE);
    assign cmd_idx    = idx_q;
    assign start_busy = ctl_q.start_bit;
    assign done       = ctl_q.done;
    assign abort_flag = ctl_q.abort;
    assign fatal_irq  = ctl_q.fatal;
    assign rst_rdy    = ctl_q.idle_rdy;
    assign state_code = ctl_q.state;
endmodule

// File: rtl/cis_checker.sv
module cis_checker #(
    parameter int CNT_W = 9
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cmd_valid,
    input logic             start_busy,
    input logic             done,
    input logic             abort_flag,
    input logic             fatal_irq,
    input logic             rst_rdy,
    input logic [CNT_W-1:0] issued_cnt,
    input logic [CNT_W-1:0] cleaned_cnt
);
    a_r2_start_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        start_busy |=> !start_busy);
    a_r2_start_before_done: assert property (@(posedge clk) disable iff (!rst_n)
        start_busy |-> !done);
    a_r3_no_back_to_back: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> !cmd_valid);
    a_r4_issue_step: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> (issued_cnt == $past(issued_cnt) + 1'b1));
    a_r5_cleaned_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        cleaned_cnt <= issued_cnt);
    a_r7_abort_irq: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(abort_flag) |-> fatal_irq);
    a_r7_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
        fatal_irq |=> !fatal_irq);
    a_r8_done_not_abort: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && abort_flag));
    a_r11_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> !rst_rdy);
endmodule

bind cache_inval_seq cis_checker #(.CNT_W(CNT_W)) u_cis_checker (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .start_busy(start_busy),
    .done(done), .abort_flag(abort_flag), .fatal_irq(fatal_irq), .rst_rdy(rst_rdy),
    .issued_cnt(issued_cnt), .cleaned_cnt(cleaned_cnt)
);

// File: tb/test_cache_inval_seq.sv
module test_cache_inval_seq;
    localparam int NE    = 8;
    localparam int CW    = 9;
    localparam int NVEC  = 6;
    // Each vector: {wait_cycles, completion delay, expect abort}
    localparam logic [16:0] VECS [NVEC] = '{
        {8'd3,  8'd0, 1'b0},
        {8'd3,  8'd3, 1'b0},
        {8'd3,  8'd4, 1'b1},
        {8'd0,  8'd0, 1'b0},
        {8'd0,  8'd1, 1'b1},
        {8'd10, 8'd5, 1'b0}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_wr = 1'b0;
    logic [7:0]    wait_cycles = 8'd0;
    logic          inv_cmp = 1'b0;
    logic          cmd_valid, start_busy, done, abort_flag, fatal_irq, rst_rdy;
    logic [CW-1:0] cmd_idx, issued_cnt, cleaned_cnt;
    logic [2:0]    state_code;

    int n_checks = 0;
    int n_fail   = 0;
    int fatal_seen = 0;

    always #4 clk = ~clk;

    cache_inval_seq #(.NUM_ENTRIES(NE), .CNT_W(CW), .TIMER_W(8)) i_cache_inval_seq (
        .clk(clk), .rst_n(rst_n), .start_wr(start_wr), .wait_cycles(wait_cycles),
        .inv_cmp(inv_cmp), .cmd_valid(cmd_valid), .cmd_idx(cmd_idx),
        .start_busy(start_busy), .done(done), .abort_flag(abort_flag),
        .fatal_irq(fatal_irq), .rst_rdy(rst_rdy), .state_code(state_code),
        .issued_cnt(issued_cnt), .cleaned_cnt(cleaned_cnt)
    );

    always @(negedge clk) if (fatal_irq) fatal_seen++;

    task automatic chk(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic run_pass(input logic [7:0] w, input int dly, input bit exp_abort,
                            input bit poke);
        int guard;
        int f0;
        f0 = fatal_seen;
        wait_cycles = w;
        @(negedge clk); start_wr = 1'b1;
        @(negedge clk); start_wr = 1'b0;
        chk("R2 start_busy set", start_busy, 1);
        chk("R2 done cleared", done, 0);
        chk("R2 counters zeroed", issued_cnt + cleaned_cnt, 0);
        chk("R11 rst_rdy low in pass", rst_rdy, 0);
        chk("R9 state ISSUE", state_code, 1);
        for (int e = 0; e < NE; e++) begin
            guard = 0;
            while (!cmd_valid && state_code != 3'd5 && guard < 100) begin
                @(negedge clk); guard++;
            end
            if (state_code == 3'd5) break;
            chk("R3 cmd_idx order", cmd_idx, e);
            chk("R4 issued before step", issued_cnt, e);
            @(negedge clk);
            chk("R4 issued after cmd", issued_cnt, e + 1);
            chk("R2 start_busy self-clears", start_busy, 0);
            if (poke && e == 2) begin
                start_wr = 1'b1;
                @(negedge clk); start_wr = 1'b0;
                chk("R10 start ignored busy", start_busy, 0);
                chk("R10 start ignored count", issued_cnt, 3);
                repeat (dly - 1) @(negedge clk);
            end else begin
                repeat (dly) @(negedge clk);
            end
            inv_cmp = 1'b1;
            @(negedge clk); inv_cmp = 1'b0;
        end
        guard = 0;
        while (state_code != 3'd4 && state_code != 3'd5 && guard < 100) begin
            @(negedge clk); guard++;
        end
        @(negedge clk);
        if (exp_abort) begin
            chk("R6 late completion aborts", state_code, 5);
            chk("R7 abort_flag", abort_flag, 1);
            chk("R7 done stays low", done, 0);
            chk("R5 cmp ignored in abort", cleaned_cnt, 0);
            chk("R7 issued held", issued_cnt, 1);
            chk("R7 single fatal pulse", fatal_seen - f0, 1);
        end else begin
            chk("R6 in-window completion", state_code, 4);
            chk("R8 done set", done, 1);
            chk("R8 issued all", issued_cnt, NE);
            chk("R8 cleaned all", cleaned_cnt, NE);
            chk("R7 no fatal", fatal_seen - f0, 0);
        end
        chk("R11 rst_rdy after pass", rst_rdy, 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 state", state_code, 0);
        chk("R1 flags", done + abort_flag + fatal_irq + start_busy + cmd_valid, 0);
        chk("R1 counters", issued_cnt + cleaned_cnt, 0);
        chk("R1 rst_rdy", rst_rdy, 1);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 idle after release", state_code, 0);

        // R5: completion in IDLE is ignored
        inv_cmp = 1'b1; @(negedge clk); inv_cmp = 1'b0; @(negedge clk);
        chk("R5 cmp ignored idle", cleaned_cnt, 0);

        for (int v = 0; v < NVEC; v++) begin
            run_pass(VECS[v][16:9], int'(VECS[v][8:1]), VECS[v][0], 1'b0);
        end

        // R5: completion while DONE is ignored
        run_pass(8'd2, 1, 1'b0, 1'b0);
        inv_cmp = 1'b1; @(negedge clk); inv_cmp = 1'b0; @(negedge clk);
        chk("R5 cmp ignored done", cleaned_cnt, NE);
        chk("R8 done holds", done, 1);

        // R10: start pulse in the middle of a pass
        run_pass(8'd5, 2, 1'b0, 1'b1);

        // R2: restart from ABORT clears the abort flag
        run_pass(8'd1, 2, 1'b1, 1'b0);
        run_pass(8'd1, 0, 1'b0, 1'b0);
        chk("R2 abort cleared by start", abort_flag, 0);

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule